// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is one timer channel running in waveform mode. A single up-counter, clocked by one of several prescaler tick inputs, counts from zero to a shared period value and then returns to zero. Two outputs, A and B, are each driven by small per-event action fields. An output can be set, cleared, toggled or left alone when the counter meets that output's own duty register, when the counter wraps at the period value, and when software issues a trigger. With "clear on duty, set on period" the result is normal-polarity PWM. Swapping the two actions gives inverted polarity. With no compare actions at all, the output holds the static level chosen by the trigger action, which covers duty 0 and duty equal to the period.

The channel is programmed through a plain register port (write strobe, byte address, write data, combinational read data). A command register starts and stops the count and issues the software trigger. A mode register holds the clock-source select, the waveform enable and the six action fields. A small two-state machine gates counting. In state ST_HALTED the counter and the outputs hold. In state ST_COUNTING each selected tick advances the counter. Transition START (ST_HALTED to ST_COUNTING) is taken on a start command that carries no stop bit. Transition STOP (ST_COUNTING to ST_HALTED) is taken on any stop command. Every other case keeps the present state.

Top module: `dual_cmp_wavegen`

## Requirements
- R1: After reset both outputs are 0, the counter reads 0 and the channel is halted, so tick inputs do not advance the counter until a start command.
- R2: Command writes at byte address 0x00 act at the clock edge of the write. Bit 0 starts counting, bit 1 stops it, and stop wins when both are set. Bit 2 is the software trigger and zeroes the counter. While halted the counter keeps its value, and a start without trigger resumes from that value.
- R3: With waveform mode on and the channel running, each selected tick adds one to the counter. On the tick where the counter equals the period register it returns to 0, so the counter reads n mod (period+1) after n ticks from a trigger.
- R4: Action codes are 00 none, 01 set, 10 clear, 11 toggle. Each output applies its duty action on the tick where the counter equals its own duty register, and its period action on the wrap tick. With duty=clear, period=set and trigger=set, an output reads 1 exactly when (n mod (period+1)) is at most its duty value.
- R5: With duty=set, period=clear and trigger=clear, the output is the inverse of the R4 waveform.
- R6: A trigger overrides any compare event in the same cycle: the counter goes to 0 and only trigger actions apply. When the period and duty events coincide, the period action wins unless it is 00, in which case the duty action applies.
- R7: The toggle action inverts the output at every matching event, so after n ticks the output equals its trigger level XOR the parity of the number of duty matches.
- R8: A command with both stop and trigger sets the outputs to their trigger levels, zeroes the counter and leaves it halted at 0 while ticks continue.
- R9: Mode bits [2:0] select tick input 0 to 4 as the count source (input 4 being the slow clock). Ticks on the other inputs have no effect, and select values 5 to 7 never advance the counter.
- R10: With waveform mode (mode bit 3) off, no action changes either output, the trigger still zeroes the counter, and the counter runs past the period value and wraps from 2^CNT_W-1 to 0.
- R11: The mode word is 16 bits: [2:0] source, [3] waveform, [5:4] A duty, [7:6] A period, [9:8] A trigger, [11:10] B duty, [13:12] B period, [15:14] B trigger. Mode (0x04), duty A (0x14), duty B (0x18) and period (0x1C) read back as written, truncated to their widths. The counter reads at 0x10. The command address and unmapped addresses read 0.
- R12: When both compare actions of an output are 00, that output keeps its trigger level for as long as the channel runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address for both read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| tick_in | input | NUM_SRC | One-cycle prescaler tick pulses, one per clock source |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |

## Verification
The hardest cases to reach from the ports are coincidences inside one clock cycle. One is a software trigger landing on the very tick where the counter sits at the period value. Another is a duty match on that same tick. The bench reaches them by counting an exact number of single ticks from a trigger, then issuing the command write and a tick together in one cycle. Duty values equal to and above the period come from a sweep of every duty value from 0 to period+1 for periods 0 to 6, with the output predicted by a closed-form modulo expression.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    // Per-event output action code
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    // Actions for one output: on its duty match, on period wrap, on trigger
    typedef struct packed {
        act_e on_trig;
        act_e on_period;
        act_e on_duty;
    } out_act_t;

    typedef enum logic {
        ST_HALTED   = 1'b0,
        ST_COUNTING = 1'b1
    } run_state_e;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned MODE_W = 16;

    localparam logic [ADDR_W-1:0] ADR_CMD    = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_CNT    = 5'h10;
    localparam logic [ADDR_W-1:0] ADR_DUTY_A = 5'h14;
    localparam logic [ADDR_W-1:0] ADR_DUTY_B = 5'h18;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 5'h1C;

    localparam int unsigned CMD_START_BIT = 0;
    localparam int unsigned CMD_STOP_BIT  = 1;
    localparam int unsigned CMD_TRIG_BIT  = 2;

    function automatic logic apply_act(input logic cur, input act_e act);
        logic res;
        unique case (act)
            ACT_NONE: res = cur;
            ACT_SET:  res = 1'b1;
            ACT_CLR:  res = 1'b0;
            ACT_TGL:  res = ~cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/wavegen_regs.sv
module wavegen_regs
    import wavegen_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_trig,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              wave_en,
    output out_act_t          act_a,
    output out_act_t          act_b,
    output logic [CNT_W-1:0]  duty_a,
    output logic [CNT_W-1:0]  duty_b,
    output logic [CNT_W-1:0]  period
);
    localparam int unsigned WAVE_BIT = SEL_W;
    localparam int unsigned ACT_LSB  = SEL_W + 1;

    logic [MODE_W-1:0] mode_q;
    logic              cmd_hit;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:MODE_W];

    // Command bits are pulses decoded straight from the write
    assign cmd_hit   = wr_en && (addr == ADR_CMD);
    assign cmd_start = cmd_hit && wr_data[CMD_START_BIT];
    assign cmd_stop  = cmd_hit && wr_data[CMD_STOP_BIT];
    assign cmd_trig  = cmd_hit && wr_data[CMD_TRIG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            duty_a <= '0;
            duty_b <= '0;
            period <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_MODE:   mode_q <= wr_data[MODE_W-1:0];
                ADR_DUTY_A: duty_a <= wr_data[CNT_W-1:0];
                ADR_DUTY_B: duty_b <= wr_data[CNT_W-1:0];
                ADR_PERIOD: period <= wr_data[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // Mode field decode
    assign clk_sel = mode_q[SEL_W-1:0];
    assign wave_en = mode_q[WAVE_BIT];
    assign act_a   = out_act_t'(mode_q[ACT_LSB +: 6]);
    assign act_b   = out_act_t'(mode_q[ACT_LSB+6 +: 6]);

    always_comb begin
        rd_data = '0;
        case (addr)
            ADR_MODE:   rd_data = DATA_W'(mode_q);
            ADR_CNT:    rd_data = DATA_W'(cnt_val);
            ADR_DUTY_A: rd_data = DATA_W'(duty_a);
            ADR_DUTY_B: rd_data = DATA_W'(duty_b);
            ADR_PERIOD: rd_data = DATA_W'(period);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wavegen_tick_sel.sv
module wavegen_tick_sel #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] tick_in,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign hit[g] = tick_in[g] && (sel == SEL_W'(g));
        end
    endgenerate

    // Select codes past the last source match nothing
    assign tick = |hit;

endmodule

// File: rtl/wavegen_core.sv
module wavegen_core
    import wavegen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_trig,
    input  logic             tick,
    input  logic             wave_en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running,
    output logic             adv,
    output logic             wrap
);
    run_state_e state_q;
    run_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    // Transitions START and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:   if (cmd_start && !cmd_stop) state_d = ST_COUNTING;
            ST_COUNTING: if (cmd_stop)               state_d = ST_HALTED;
        endcase
    end

    // State outputs
    always_comb begin
        running = (state_q == ST_COUNTING);
        adv     = running && tick && !cmd_trig;
        wrap    = adv && wave_en && (cnt_q == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cmd_trig) cnt_q <= '0;
        else if (wrap)     cnt_q <= '0;
        else if (adv)      cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/wavegen_out_unit.sv
module wavegen_out_unit
    import wavegen_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave_en,
    input  logic             adv,
    input  logic             wrap,
    input  logic             trig,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    input  out_act_t         act,
    output logic             wave_out
);
    logic hit_duty;
    logic nxt;

    assign hit_duty = adv && wave_en && (cnt == duty);

    // Trigger first, then period wrap (if it has an action), then duty
    always_comb begin
        nxt = wave_out;
        if (wave_en) begin
            if (trig)
                nxt = apply_act(wave_out, act.on_trig);
            else if (wrap && (act.on_period != ACT_NONE))
                nxt = apply_act(wave_out, act.on_period);
            else if (hit_duty)
                nxt = apply_act(wave_out, act.on_duty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_out <= 1'b0;
        else        wave_out <= nxt;
    end

endmodule

// File: rtl/dual_cmp_wavegen.sv
module dual_cmp_wavegen
    import wavegen_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] tick_in,
    output logic               wave_a,
    output logic               wave_b
);
    localparam int unsigned NUM_OUT = 2;

    logic             cmd_start;
    logic             cmd_stop;
    logic             cmd_trig;
    logic [SEL_W-1:0] clk_sel;
    logic             wave_en;
    out_act_t         act_a;
    out_act_t         act_b;
    logic [CNT_W-1:0] duty_a;
    logic [CNT_W-1:0] duty_b;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             running;
    logic             adv;
    logic             wrap;

    out_act_t         act_v  [NUM_OUT];
    logic [CNT_W-1:0] duty_v [NUM_OUT];
    logic [NUM_OUT-1:0] wave_v;

    wavegen_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cnt_val   (cnt_q),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_trig  (cmd_trig),
        .clk_sel   (clk_sel),
        .wave_en   (wave_en),
        .act_a     (act_a),
        .act_b     (act_b),
        .duty_a    (duty_a),
        .duty_b    (duty_b),
        .period    (period_q)
    );

    wavegen_tick_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) sel_i (
        .tick_in (tick_in),
        .sel     (clk_sel),
        .tick    (tick)
    );

    wavegen_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_trig  (cmd_trig),
        .tick      (tick),
        .wave_en   (wave_en),
        .period    (period_q),
        .cnt_q     (cnt_q),
        .running   (running),
        .adv       (adv),
        .wrap      (wrap)
    );

    assign act_v[0]  = act_a;
    assign act_v[1]  = act_b;
    assign duty_v[0] = duty_a;
    assign duty_v[1] = duty_b;

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
            wavegen_out_unit #(
                .CNT_W (CNT_W)
            ) out_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wave_en  (wave_en),
                .adv      (adv),
                .wrap     (wrap),
                .trig     (cmd_trig),
                .cnt      (cnt_q),
                .duty     (duty_v[g]),
                .act      (act_v[g]),
                .wave_out (wave_v[g])
            );
        end
    endgenerate

    assign wave_a = wave_v[0];
    assign wave_b = wave_v[1];

endmodule

// File: rtl/wavegen_checker.sv
module wavegen_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             adv,
    input logic             wrap,
    input logic             trig,
    input logic             wave_en,
    input logic [CNT_W-1:0] cnt,
    input logic             wave_a,
    input logic             wave_b
);
    // R3: a plain advance adds one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R3: the wrap tick returns the counter to zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    // R6: a trigger always leaves the counter at zero
    a_r6_trig_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == '0));

    // R2: halted without trigger, nothing moves
    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !trig) |=> ($stable(cnt) && $stable(wave_a) && $stable(wave_b)));

    // R10: outputs frozen outside waveform mode
    a_r10_nowave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_en |=> ($stable(wave_a) && $stable(wave_b)));

endmodule

bind dual_cmp_wavegen wavegen_checker #(
    .CNT_W (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .adv     (adv),
    .wrap    (wrap),
    .trig    (cmd_trig),
    .wave_en (wave_en),
    .cnt     (cnt_q),
    .wave_a  (wave_a),
    .wave_b  (wave_b)
);

// File: tb/dual_cmp_wavegen_tb_top.sv
module dual_cmp_wavegen_tb_top;
    import wavegen_pkg::*;

    localparam int unsigned CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  tick_in = '0;
    logic        wave_a;
    logic        wave_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_cmp_wavegen #(
        .DATA_W  (32),
        .CNT_W   (CNT_W),
        .NUM_SRC (5),
        .SEL_W   (3)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .tick_in (tick_in),
        .wave_a  (wave_a),
        .wave_b  (wave_b)
    );

    function automatic logic [15:0] mk_mode(input int sel, input bit wave,
        input act_e ad, input act_e ap, input act_e at,
        input act_e bd, input act_e bp, input act_e bt);
        return {bt, bp, bd, at, ap, ad, wave, 3'(sel)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [4:0] a, input logic [31:0] d, input logic [4:0] m);
        wr_en = 1'b1; addr = a; wr_data = d; tick_in = m;
        @(negedge clk);
        wr_en = 1'b0; tick_in = '0;
    endtask

    task automatic ticks(input int n, input logic [4:0] m);
        for (int i = 0; i < n; i++) begin
            tick_in = m;
            @(negedge clk);
        end
        tick_in = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic setup(input int rc, input int ra, input int rb, input logic [15:0] mode);
        wr(ADR_CMD, 32'h2);
        wr(ADR_DUTY_A, 32'(ra));
        wr(ADR_DUTY_B, 32'(rb));
        wr(ADR_PERIOD, 32'(rc));
        wr(ADR_MODE, {16'h0, mode});
        wr(ADR_CMD, 32'h5);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic int dmatch(input int n, input int r, input int m);
        return (n > r) ? ((n - r - 1) / m + 1) : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] md;
        logic        ha;
        logic        hb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and halted after reset
        rd(ADR_CNT, v);
        check("R1", "cnt", v, 0);
        check("R1", "wave_a", 32'(wave_a), 0);
        check("R1", "wave_b", 32'(wave_b), 0);
        ticks(5, 5'b11111);
        rd(ADR_CNT, v);
        check("R1", "cnt after ticks", v, 0);

        // R11: readback
        wr(ADR_MODE, 32'hABCD_5A6B);
        rd(ADR_MODE, v);     check("R11", "mode", v, 32'h5A6B);
        wr(ADR_DUTY_A, 32'h1FF);
        rd(ADR_DUTY_A, v);   check("R11", "duty_a", v, 32'hFF);
        wr(ADR_DUTY_B, 32'h37);
        rd(ADR_DUTY_B, v);   check("R11", "duty_b", v, 32'h37);
        wr(ADR_PERIOD, 32'hC5);
        rd(ADR_PERIOD, v);   check("R11", "period", v, 32'hC5);
        rd(ADR_CMD, v);      check("R11", "cmd", v, 0);
        rd(5'h08, v);        check("R11", "unmapped", v, 0);

        // R3 R4 R6: sweep of period and duty, normal polarity
        md = mk_mode(0, 1'b1, ACT_CLR, ACT_SET, ACT_SET, ACT_CLR, ACT_SET, ACT_SET);
        for (int rc = 0; rc <= 6; rc++) begin
            for (int ra = 0; ra <= rc + 1; ra++) begin
                int rb;
                int m;
                rb = (ra * 3 + 1) % (rc + 2);
                m = rc + 1;
                setup(rc, ra, rb, md);
                for (int n = 0; n <= 2 * m + 1; n++) begin
                    rd(ADR_CNT, v);
                    check("R3", "cnt", v, 32'(n % m));
                    check("R4", "wave_a", 32'(wave_a), ((n % m) <= ra) ? 1 : 0);
                    check("R4", "wave_b", 32'(wave_b), ((n % m) <= rb) ? 1 : 0);
                    ticks(1, 5'b00001);
                end
            end
        end

        // R5: inverted polarity
        md = mk_mode(0, 1'b1, ACT_SET, ACT_CLR, ACT_CLR, ACT_SET, ACT_CLR, ACT_CLR);
        for (int ra = 0; ra <= 6; ra++) begin
            setup(5, ra, 5 - (ra % 6), md);
            for (int n = 0; n <= 13; n++) begin
                check("R5", "wave_a", 32'(wave_a), ((n % 6) <= ra) ? 0 : 1);
                check("R5", "wave_b", 32'(wave_b), ((n % 6) <= 5 - (ra % 6)) ? 0 : 1);
                ticks(1, 5'b00001);
            end
        end

        // R7: toggle
        md = mk_mode(0, 1'b1, ACT_TGL, ACT_NONE, ACT_CLR, ACT_TGL, ACT_NONE, ACT_SET);
        setup(4, 2, 0, md);
        for (int n = 0; n <= 16; n++) begin
            check("R7", "wave_a", 32'(wave_a), 32'(dmatch(n, 2, 5) % 2));
            check("R7", "wave_b", 32'(wave_b), 32'(1 - dmatch(n, 0, 5) % 2));
            ticks(1, 5'b00001);
        end

        // R6: trigger on the wrap tick, and fallthrough to duty action
        md = mk_mode(0, 1'b1, ACT_NONE, ACT_SET, ACT_CLR, ACT_CLR, ACT_NONE, ACT_SET);
        setup(3, 0, 3, md);
        ticks(3, 5'b00001);
        rd(ADR_CNT, v);      check("R6", "cnt at period", v, 3);
        wr_tick(ADR_CMD, 32'h4, 5'b00001);
        rd(ADR_CNT, v);      check("R6", "cnt after trig", v, 0);
        check("R6", "wave_a trig beats period", 32'(wave_a), 0);
        check("R6", "wave_b trig beats duty", 32'(wave_b), 1);
        ticks(1, 5'b00001);
        rd(ADR_CNT, v);      check("R6", "cnt", v, 1);
        ticks(3, 5'b00001);
        rd(ADR_CNT, v);      check("R6", "cnt wrapped", v, 0);
        check("R6", "wave_a period set", 32'(wave_a), 1);
        check("R6", "wave_b duty when period none", 32'(wave_b), 0);

        // R8 R2: stop with trigger, plain stop, resume
        md = mk_mode(0, 1'b1, ACT_CLR, ACT_SET, ACT_SET, ACT_SET, ACT_CLR, ACT_CLR);
        setup(9, 5, 5, md);
        ticks(7, 5'b00001);
        check("R4", "wave_a before stop", 32'(wave_a), 0);
        check("R4", "wave_b before stop", 32'(wave_b), 1);
        wr(ADR_CMD, 32'h6);
        rd(ADR_CNT, v);      check("R8", "cnt", v, 0);
        check("R8", "wave_a", 32'(wave_a), 1);
        check("R8", "wave_b", 32'(wave_b), 0);
        ticks(5, 5'b00001);
        rd(ADR_CNT, v);      check("R8", "cnt halted", v, 0);
        check("R8", "wave_a held", 32'(wave_a), 1);
        wr(ADR_CMD, 32'h5);
        ticks(7, 5'b00001);
        wr(ADR_CMD, 32'h2);
        ticks(4, 5'b00001);
        rd(ADR_CNT, v);      check("R2", "cnt held", v, 7);
        check("R2", "wave_a held", 32'(wave_a), 0);
        check("R2", "wave_b held", 32'(wave_b), 1);
        wr(ADR_CMD, 32'h1);
        ticks(1, 5'b00001);
        rd(ADR_CNT, v);      check("R2", "resume", v, 8);
        wr(ADR_CMD, 32'h3);
        ticks(2, 5'b00001);
        rd(ADR_CNT, v);      check("R2", "stop wins", v, 8);

        // R9: clock select
        setup(200, 250, 250, mk_mode(2, 1'b1, ACT_CLR, ACT_SET, ACT_SET, ACT_CLR, ACT_SET, ACT_SET));
        ticks(4, 5'b11011);
        rd(ADR_CNT, v);      check("R9", "other sources", v, 0);
        ticks(3, 5'b00100);
        rd(ADR_CNT, v);      check("R9", "source 2", v, 3);
        wr(ADR_MODE, {16'h0, mk_mode(4, 1'b1, ACT_CLR, ACT_SET, ACT_SET, ACT_CLR, ACT_SET, ACT_SET)});
        ticks(2, 5'b10000);
        rd(ADR_CNT, v);      check("R9", "slow source", v, 5);
        ticks(2, 5'b01111);
        rd(ADR_CNT, v);      check("R9", "slow others", v, 5);
        wr(ADR_MODE, {16'h0, mk_mode(6, 1'b1, ACT_CLR, ACT_SET, ACT_SET, ACT_CLR, ACT_SET, ACT_SET)});
        ticks(3, 5'b11111);
        rd(ADR_CNT, v);      check("R9", "select 6", v, 5);

        // R10: waveform mode off
        ha = wave_a;
        hb = wave_b;
        setup(3, 1, 2, mk_mode(0, 1'b0, ACT_TGL, ACT_TGL, ACT_TGL, ACT_TGL, ACT_TGL, ACT_TGL));
        rd(ADR_CNT, v);      check("R10", "trig zero", v, 0);
        check("R10", "wave_a", 32'(wave_a), 32'(ha));
        check("R10", "wave_b", 32'(wave_b), 32'(hb));
        ticks(10, 5'b00001);
        rd(ADR_CNT, v);      check("R10", "past period", v, 10);
        check("R10", "wave_a held", 32'(wave_a), 32'(ha));
        check("R10", "wave_b held", 32'(wave_b), 32'(hb));
        ticks(245, 5'b00001);
        rd(ADR_CNT, v);      check("R10", "top", v, 255);
        ticks(1, 5'b00001);
        rd(ADR_CNT, v);      check("R10", "width wrap", v, 0);

        // R12: static levels with no compare actions
        setup(5, 0, 0, mk_mode(0, 1'b1, ACT_NONE, ACT_NONE, ACT_CLR, ACT_NONE, ACT_NONE, ACT_SET));
        for (int n = 0; n <= 13; n++) begin
            check("R12", "wave_a", 32'(wave_a), 0);
            check("R12", "wave_b", 32'(wave_b), 1);
            ticks(1, 5'b00001);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule